// File: doc/BRIEF.md
# Message and Process Communication Port

The block is a hardware rendezvous queue between producing and consuming processes. A single storage array holds one of two kinds of entry. Either it holds messages that no receiver has taken yet, or it holds the IDs of receivers that are waiting for a message. It never holds both kinds at once. Callers issue one command per cycle, tagged with a process ID. The command is a send or a receive, each in a blocking and a non-blocking (conditional) form. The port answers each command with a status of satisfied, blocked or refused.

When a message and a waiting party meet, the port emits a wake event naming the party to resume and the message it carries. The message goes straight to a waiting receiver and does not pass through storage. A sender that blocked on a full queue is released when a receive frees a slot. Its message is appended at the tail in that same cycle. A dispatch queue is the same block with process IDs used as the message payload.

Top module: `msg_port`

## Requirements
- R1: After reset the port reports occupancy 0, mode 0, and neither a response nor a wake event is valid.
- R2: A send (op 0) or conditional send (op 2) to a port in mode 0 that is not full stores the message at the tail, responds with status 0 (satisfied) and raises occupancy by one.
- R3: A receive (op 1) or conditional receive (op 3) on a port in mode 0 holding messages responds with status 0 and returns the oldest stored message on the response message output, lowering occupancy by one.
- R4: A receive (op 1) on a port holding no messages responds with status 1 (blocked), enqueues the caller ID as a waiting receiver and sets mode 1 (receivers waiting).
- R5: A send or conditional send while mode is 1 responds with status 0, stores nothing and emits a wake event carrying the oldest waiter's ID and the sent message. It lowers occupancy by one and returns to mode 0 when the last waiter is taken.
- R6: Waiting receivers are woken in the order in which they blocked.
- R7: A send (op 0) to a full message queue responds with status 1 and records the sender. A later receive returns the head message, appends the blocked sender's message at the tail, emits a wake event with that sender's ID and message, and leaves occupancy unchanged. Blocked senders are released oldest first.
- R8: A conditional send to a full message queue responds with status 2 (refused) and leaves occupancy and contents unchanged.
- R9: A conditional receive on a port with no stored messages responds with status 2 and enqueues nothing.
- R10: A receive when the waiter queue is full, or a send when both the message queue and the blocked-sender record are full, responds with status 2 and changes nothing.
- R11: Blocked senders exist only while the port is in mode 0 with a full message queue.
- R12: A cycle without a valid command produces no response, no wake event and no change of occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 send, 1 receive, 2 conditional send, 3 conditional receive |
| cmd_pid_i | input | ID_W | Caller process ID |
| cmd_msg_i | input | MSG_W | Message for send commands |
| rsp_valid_o | output | 1 | Response for the previous cycle's command |
| rsp_status_o | output | 2 | 0 satisfied, 1 blocked, 2 refused |
| rsp_msg_o | output | MSG_W | Message delivered to a satisfied receiver, else 0 |
| wake_valid_o | output | 1 | A waiting process is released |
| wake_pid_o | output | ID_W | ID of the released process |
| wake_msg_o | output | MSG_W | Message handed over with the release |
| mode_o | output | 1 | 0 messages held, 1 receivers waiting |
| count_o | output | CNT_W | Entries held in the shared array |

## Verification
The hardest state to reach is a full message queue with a full blocked-sender record. Only in that state does a receive have to pop, push and wake in one cycle, and a further send have to be refused. The bench fills the array with four plain sends and then issues two blocking sends from distinct IDs. A third send checks the refusal. It then drains with receives, checking at each step the head order, the sender wakes and the constant occupancy. A similar sequence fills the array with waiters to reach the refused receive.

// File: rtl/msg_port_pkg.sv
package msg_port_pkg;
  typedef enum logic [1:0] {
    OP_SEND  = 2'd0,
    OP_RECV  = 2'd1,
    OP_CSEND = 2'd2,
    OP_CRECV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BLOCKED = 2'd1,
    ST_REFUSED = 2'd2
  } status_e;
endpackage

// File: rtl/port_ring.sv
module port_ring #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  // push into a full ring is legal only alongside a pop
  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
  import msg_port_pkg::*;
#(
  parameter int ID_W  = 6,
  parameter int MSG_W = 16,
  parameter int CNT_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_op_i,
  input  logic [ID_W-1:0]      cmd_pid_i,
  input  logic [MSG_W-1:0]     cmd_msg_i,
  // shared array
  input  logic [MSG_W-1:0]     q_head_i,
  input  logic [CNT_W-1:0]     q_count_i,
  input  logic                 q_full_i,
  input  logic                 q_empty_i,
  output logic                 q_push_o,
  output logic                 q_pop_o,
  output logic [MSG_W-1:0]     q_wdata_o,
  // blocked-sender record
  input  logic [ID_W+MSG_W-1:0] sw_head_i,
  input  logic                 sw_full_i,
  input  logic                 sw_empty_i,
  output logic                 sw_push_o,
  output logic                 sw_pop_o,
  output logic [ID_W+MSG_W-1:0] sw_wdata_o,
  // results
  output logic                 rsp_valid_o,
  output logic [1:0]           rsp_status_o,
  output logic [MSG_W-1:0]     rsp_msg_o,
  output logic                 wake_valid_o,
  output logic [ID_W-1:0]      wake_pid_o,
  output logic [MSG_W-1:0]     wake_msg_o,
  output logic                 mode_o
);
  op_e             op;
  status_e         st_d;
  logic            mode_q, mode_d;
  logic            wake_d, enq_waiter;
  logic [ID_W-1:0] wpid_d;
  logic [MSG_W-1:0] wmsg_d, rmsg_d;
  logic [ID_W-1:0] sw_pid;
  logic [MSG_W-1:0] sw_msg;

  logic            rsp_valid_q, wake_valid_q;
  logic [1:0]      rsp_status_q;
  logic [MSG_W-1:0] rsp_msg_q, wake_msg_q;
  logic [ID_W-1:0] wake_pid_q;

  assign op = op_e'(cmd_op_i);
  assign {sw_pid, sw_msg} = sw_head_i;
  assign sw_wdata_o = {cmd_pid_i, cmd_msg_i};

  always_comb begin
    q_push_o   = 1'b0;
    q_pop_o    = 1'b0;
    q_wdata_o  = cmd_msg_i;
    sw_push_o  = 1'b0;
    sw_pop_o   = 1'b0;
    st_d       = ST_REFUSED;
    wake_d     = 1'b0;
    wpid_d     = '0;
    wmsg_d     = '0;
    rmsg_d     = '0;
    enq_waiter = 1'b0;
    if (cmd_valid_i) begin
      unique case (op)
        OP_SEND, OP_CSEND: begin
          if (mode_q) begin
            // hand the message straight to the oldest waiter
            q_pop_o = 1'b1;
            wake_d  = 1'b1;
            wpid_d  = q_head_i[ID_W-1:0];
            wmsg_d  = cmd_msg_i;
            st_d    = ST_OK;
          end else if (!q_full_i) begin
            q_push_o = 1'b1;
            st_d     = ST_OK;
          end else if (op == OP_SEND && !sw_full_i) begin
            sw_push_o = 1'b1;
            st_d      = ST_BLOCKED;
          end
        end
        OP_RECV, OP_CRECV: begin
          if (!mode_q && !q_empty_i) begin
            q_pop_o = 1'b1;
            rmsg_d  = q_head_i;
            st_d    = ST_OK;
            if (!sw_empty_i) begin
              // freed slot goes to the oldest blocked sender
              sw_pop_o  = 1'b1;
              q_push_o  = 1'b1;
              q_wdata_o = sw_msg;
              wake_d    = 1'b1;
              wpid_d    = sw_pid;
              wmsg_d    = sw_msg;
            end
          end else if (op == OP_RECV && !q_full_i) begin
            q_push_o   = 1'b1;
            q_wdata_o  = MSG_W'(cmd_pid_i);
            enq_waiter = 1'b1;
            st_d       = ST_BLOCKED;
          end
        end
        default: st_d = ST_REFUSED;
      endcase
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (enq_waiter) mode_d = 1'b1;
    else if (mode_q && q_pop_o && q_count_i == CNT_W'(1)) mode_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= 1'b0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= ST_OK;
      rsp_msg_q    <= '0;
      wake_valid_q <= 1'b0;
      wake_pid_q   <= '0;
      wake_msg_q   <= '0;
    end else begin
      mode_q       <= mode_d;
      rsp_valid_q  <= cmd_valid_i;
      rsp_status_q <= cmd_valid_i ? st_d : ST_OK;
      rsp_msg_q    <= rmsg_d;
      wake_valid_q <= wake_d;
      wake_pid_q   <= wpid_d;
      wake_msg_q   <= wmsg_d;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_status_o = rsp_status_q;
  assign rsp_msg_o    = rsp_msg_q;
  assign wake_valid_o = wake_valid_q;
  assign wake_pid_o   = wake_pid_q;
  assign wake_msg_o   = wake_msg_q;
  assign mode_o       = mode_q;

  // waiter mode is only meaningful with waiters present
  assert_waiters_present_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> !q_empty_i);
  assert_sender_wait_only_full_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_empty_i |-> (!mode_q && q_full_i));
  assert_cond_never_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i[1]) |=> (rsp_status_o != ST_BLOCKED));
  assert_wake_from_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_valid_o |-> rsp_valid_o);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!rsp_valid_o && !wake_valid_o && $stable(mode_o)));
endmodule

// File: rtl/msg_port.sv
module msg_port
  import msg_port_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SW_DEPTH = 2,
  parameter int ID_W     = 6,
  parameter int MSG_W    = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SWC_W   = $clog2(SW_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [ID_W-1:0]  cmd_pid_i,
  input  logic [MSG_W-1:0] cmd_msg_i,
  output logic             rsp_valid_o,
  output logic [1:0]       rsp_status_o,
  output logic [MSG_W-1:0] rsp_msg_o,
  output logic             wake_valid_o,
  output logic [ID_W-1:0]  wake_pid_o,
  output logic [MSG_W-1:0] wake_msg_o,
  output logic             mode_o,
  output logic [CNT_W-1:0] count_o
);
  logic                  q_push, q_pop, q_full, q_empty;
  logic [MSG_W-1:0]      q_wdata, q_head;
  logic                  sw_push, sw_pop, sw_full, sw_empty;
  logic [ID_W+MSG_W-1:0] sw_wdata, sw_head;
  logic [SWC_W-1:0]      sw_count;

  port_ring #(.W(MSG_W), .DEPTH(DEPTH)) u_slots (
    .clk_i, .rst_ni,
    .push_i(q_push), .pop_i(q_pop), .wdata_i(q_wdata),
    .head_o(q_head), .count_o(count_o), .full_o(q_full), .empty_o(q_empty)
  );

  port_ring #(.W(ID_W + MSG_W), .DEPTH(SW_DEPTH)) u_sender_wait (
    .clk_i, .rst_ni,
    .push_i(sw_push), .pop_i(sw_pop), .wdata_i(sw_wdata),
    .head_o(sw_head), .count_o(sw_count), .full_o(sw_full), .empty_o(sw_empty)
  );

  port_ctrl #(.ID_W(ID_W), .MSG_W(MSG_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_op_i, .cmd_pid_i, .cmd_msg_i,
    .q_head_i(q_head), .q_count_i(count_o), .q_full_i(q_full), .q_empty_i(q_empty),
    .q_push_o(q_push), .q_pop_o(q_pop), .q_wdata_o(q_wdata),
    .sw_head_i(sw_head), .sw_full_i(sw_full), .sw_empty_i(sw_empty),
    .sw_push_o(sw_push), .sw_pop_o(sw_pop), .sw_wdata_o(sw_wdata),
    .rsp_valid_o, .rsp_status_o, .rsp_msg_o,
    .wake_valid_o, .wake_pid_o, .wake_msg_o, .mode_o
  );

  initial begin
    assert_id_fits_msg_R5: assert (ID_W <= MSG_W);
  end

  assert_sw_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_count <= SWC_W'(SW_DEPTH));
endmodule

// File: tb/msg_port_tb_top.sv
module msg_port_tb_top;
  localparam int ID_W = 6;
  localparam int MSG_W = 16;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = '0;
  logic [ID_W-1:0]  cmd_pid = '0;
  logic [MSG_W-1:0] cmd_msg = '0;
  logic             rsp_valid, wake_valid, mode;
  logic [1:0]       rsp_status;
  logic [MSG_W-1:0] rsp_msg, wake_msg;
  logic [ID_W-1:0]  wake_pid;
  logic [CNT_W-1:0] count;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  msg_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_pid_i(cmd_pid), .cmd_msg_i(cmd_msg),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_msg_o(rsp_msg),
    .wake_valid_o(wake_valid), .wake_pid_o(wake_pid), .wake_msg_o(wake_msg),
    .mode_o(mode), .count_o(count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [ID_W-1:0] pid, logic [MSG_W-1:0] msg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_pid = pid; cmd_msg = msg;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", 32'(count), 0);
    check("R1 mode", 32'(mode), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 wake_valid", 32'(wake_valid), 0);
  endtask

  task automatic t_send_recv_fifo;
    for (int i = 0; i < 3; i++) begin
      issue(2'd0, 6'd1, 16'hA000 + 16'(i));
      check("R2 status", 32'(rsp_status), 0);
      check("R2 count", 32'(count), 32'(i + 1));
    end
    issue(2'd1, 6'd2, '0);
    check("R3 msg oldest", 32'(rsp_msg), 32'hA000);
    check("R3 status", 32'(rsp_status), 0);
    issue(2'd3, 6'd2, '0);
    check("R3 cond recv msg", 32'(rsp_msg), 32'hA001);
    issue(2'd1, 6'd2, '0);
    check("R3 msg third", 32'(rsp_msg), 32'hA002);
    check("R3 count", 32'(count), 0);
  endtask

  task automatic t_recv_block;
    issue(2'd1, 6'd5, '0);
    check("R4 status", 32'(rsp_status), 1);
    check("R4 mode", 32'(mode), 1);
    check("R4 count", 32'(count), 1);
    issue(2'd1, 6'd7, '0);
    check("R4 count two", 32'(count), 2);
    issue(2'd2, 6'd9, 16'h1234);
    check("R5 status", 32'(rsp_status), 0);
    check("R5 wake", 32'(wake_valid), 1);
    check("R5 wake pid", 32'(wake_pid), 5);
    check("R5 wake msg", 32'(wake_msg), 32'h1234);
    check("R5 count", 32'(count), 1);
    issue(2'd0, 6'd9, 16'h5678);
    check("R6 wake pid", 32'(wake_pid), 7);
    check("R5 wake msg2", 32'(wake_msg), 32'h5678);
    check("R5 mode back", 32'(mode), 0);
    check("R5 count zero", 32'(count), 0);
  endtask

  task automatic t_cond_recv;
    issue(2'd3, 6'd4, '0);
    check("R9 status empty", 32'(rsp_status), 2);
    check("R9 count", 32'(count), 0);
    check("R9 mode", 32'(mode), 0);
    issue(2'd1, 6'd3, '0);
    issue(2'd3, 6'd4, '0);
    check("R9 status waiters", 32'(rsp_status), 2);
    check("R9 count unchanged", 32'(count), 1);
    issue(2'd0, 6'd8, 16'h0BEE);
    check("R9 wake pid3", 32'(wake_pid), 3);
    issue(2'd0, 6'd8, 16'h0C00);
    // pid 4 was never enqueued: this send is stored
    check("R9 no stray waiter", 32'(wake_valid), 0);
    check("R9 stored", 32'(count), 1);
    issue(2'd1, 6'd8, '0);
    check("R3 drain", 32'(rsp_msg), 32'h0C00);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) issue(2'd0, 6'd1, 16'hB000 + 16'(i));
    check("R2 full count", 32'(count), 4);
    issue(2'd2, 6'd1, 16'hDEAD);
    check("R8 status", 32'(rsp_status), 2);
    check("R8 count", 32'(count), 4);
    issue(2'd0, 6'd10, 16'hC010);
    check("R7 blocked", 32'(rsp_status), 1);
    issue(2'd0, 6'd11, 16'hC011);
    check("R7 blocked2", 32'(rsp_status), 1);
    issue(2'd0, 6'd12, 16'hC012);
    check("R10 sender record full", 32'(rsp_status), 2);
    issue(2'd1, 6'd1, '0);
    check("R7 head", 32'(rsp_msg), 32'hB000);
    check("R7 wake", 32'(wake_valid), 1);
    check("R7 wake pid", 32'(wake_pid), 10);
    check("R7 wake msg", 32'(wake_msg), 32'hC010);
    check("R11 count full", 32'(count), 4);
    issue(2'd1, 6'd1, '0);
    check("R7 head2", 32'(rsp_msg), 32'hB001);
    check("R7 wake pid2", 32'(wake_pid), 11);
    issue(2'd1, 6'd1, '0);
    check("R11 no more senders", 32'(wake_valid), 0);
    check("R11 count drops", 32'(count), 3);
    issue(2'd1, 6'd1, '0);
    check("R3 b3", 32'(rsp_msg), 32'hB003);
    issue(2'd1, 6'd1, '0);
    check("R7 appended1", 32'(rsp_msg), 32'hC010);
    issue(2'd1, 6'd1, '0);
    check("R7 appended2", 32'(rsp_msg), 32'hC011);
    check("R7 empty", 32'(count), 0);
  endtask

  task automatic t_waiter_full;
    for (int i = 0; i < 4; i++) issue(2'd1, 6'(20 + i), '0);
    check("R4 waiters full", 32'(count), 4);
    issue(2'd1, 6'd30, '0);
    check("R10 recv refused", 32'(rsp_status), 2);
    check("R10 count", 32'(count), 4);
    for (int i = 0; i < 4; i++) begin
      issue(2'd0, 6'd1, 16'hE000 + 16'(i));
      check("R6 wake order", 32'(wake_pid), 32'(20 + i));
    end
    check("R6 mode", 32'(mode), 0);
  endtask

  task automatic t_idle;
    issue(2'd0, 6'd1, 16'hF00D);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R12 rsp", 32'(rsp_valid), 0);
      check("R12 count", 32'(count), 1);
    end
    issue(2'd1, 6'd1, '0);
    check("R12 content kept", 32'(rsp_msg), 32'hF00D);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    t_send_recv_fifo();
    t_recv_block();
    t_cond_recv();
    t_full();
    t_waiter_full();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule